// File: doc/BRIEF.md
# Video RAM Bus Arbiter

This block lets a host processor and a graphics display controller share one video RAM data bus. It samples the controller's row strobe on the falling edge of a doubled host clock and uses the result as a slot signal. When the slot signal is high, the host owns the bus. When it is low, the controller owns it. From the slot signal, the pending host request and the controller's drawing request, the block decides which bank transceiver, which side buffer and which data direction are active in each cycle.

All outputs are registered on the rising edge of the doubled clock. The enables are active low: one per RAM bank, one for the controller-side buffer and one for the host-side buffer. There is also a strobe that latches host read data, and a direction line that rests at read. A host request that arrives in a controller slot is held pending and is served in the next host slot. A ready output stays low until the held request has been served.

Top module: `vram_bus_arb`

## Requirements
- R1: `slot` is `gfx_ras` sampled on each falling edge of `clk2x`. A host access (`cde_n` low or `rd_latch` high) appears only after a rising edge at which `slot` was 1. A controller request made while `slot` is 1 produces no output.
- R2: A controller drawing access (`gde_n` low) appears only after a rising edge at which `slot` was 0.
- R3: With no access in progress (display fetch or refresh), the outputs are all inactive: `vde_n` = 3'b111, `gde_n` = 1, `cde_n` = 1, `rd_latch` = 0, `dbd_we` = 0.
- R4: A host read (`cpu_we` = 0) to bank b drives only `vde_n[b]` low and `rd_latch` high. `cde_n` stays high and `dbd_we` stays 0.
- R5: A host write (`cpu_we` = 1) to bank b drives `cde_n` and `vde_n[b]` low and sets `dbd_we` to 1.
- R6: A controller drawing access to bank b drives `gde_n` and `vde_n[b]` low. `dbd_we` equals `gfx_we`.
- R7: When `gfx_addr_hi` = 2'b11 (the mapping region), `vde_n[b]` still goes low but `gde_n` stays high.
- R8: Bank code 3 on `cpu_bank` or `gfx_bank` means no access. All enables stay high, `rd_latch` stays 0 and `dbd_we` stays 0. A host request with this code counts as served.
- R9: A host request (`cpu_req` high while `cpu_ready` = 1) made while `slot` is 0 is held. `cpu_ready` goes low after that edge. The request is served after the first rising edge with `slot` = 1, and `cpu_ready` returns to 1 at the same time. While `cpu_ready` = 0, `cpu_req` is ignored.
- R10: While `rst_n` is low, and immediately when it falls, all enables are high, `rd_latch` and `dbd_we` are 0, `cpu_ready` is 1 and any held request is dropped.
- R11: `gde_n` and `cde_n` are never low in the same cycle.
- R12: Outputs change only at rising edges of `clk2x`. Inputs presented before a rising edge (with `gfx_ras` also seen at the falling edge before it) take effect on the outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Doubled host clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gfx_ras | input | 1 | Controller row strobe level, sampled on falling edges |
| cpu_req | input | 1 | Host access request |
| cpu_we | input | 1 | Host direction, 1 = write |
| cpu_bank | input | 2 | Host bank code, 0 to 2, 3 = none |
| gfx_draw_req | input | 1 | Controller drawing request |
| gfx_we | input | 1 | Controller direction, 1 = write |
| gfx_bank | input | 2 | Controller bank code, 0 to 2, 3 = none |
| gfx_addr_hi | input | 2 | Controller address bits 17:16 |
| vde_n | output | 3 | Per-bank transceiver enables, active low |
| gde_n | output | 1 | Controller-side buffer enable, active low |
| cde_n | output | 1 | Host-side buffer enable, active low |
| rd_latch | output | 1 | Host read-data latch strobe |
| dbd_we | output | 1 | RAM direction, 1 = write, 0 = read |
| cpu_ready | output | 1 | Low while a host request is held |

## Verification
Each result is due exactly one rising edge after the inputs that cause it. The exception is the slot level, which comes from `gfx_ras` seen at the falling edge half a cycle earlier. The bench therefore drives every input 1 ns after a rising edge and checks all outputs 1 ns after the next rising edge. A held host request takes longer: it is checked after each edge until the first edge with the slot high, and `cpu_ready` is checked on the same schedule. Reset is checked 1 ns after `rst_n` falls, without waiting for any clock edge.

// File: rtl/vram_arb_pkg.sv
package vram_arb_pkg;

    localparam int NUM_BANKS = 3;
    localparam int BANK_W    = 2;
    localparam int AHI_W     = 2;

    typedef struct packed {
        logic [NUM_BANKS-1:0] vde_n;
        logic                 gde_n;
        logic                 cde_n;
        logic                 rd_latch;
        logic                 dbd_we;
    } bus_ctl_t;

    localparam bus_ctl_t BUS_IDLE = '{
        vde_n:    '1,
        gde_n:    1'b1,
        cde_n:    1'b1,
        rd_latch: 1'b0,
        dbd_we:   1'b0
    };

    typedef struct packed {
        logic              vld;
        logic              we;
        logic [BANK_W-1:0] bank;
    } host_pend_t;

endpackage

// File: rtl/vram_slot_gen.sv
module vram_slot_gen (
    input  logic clk2x,
    input  logic rst_n,
    input  logic row_strobe,
    output logic slot
);

    logic slot_d, slot_q;

    always_comb begin
        slot_d = row_strobe;
    end

    // sampled on the falling edge so the level is stable at the next rising edge
    always_ff @(negedge clk2x or negedge rst_n) begin
        if (!rst_n) slot_q <= 1'b0;
        else        slot_q <= slot_d;
    end

    assign slot = slot_q;

endmodule

// File: rtl/vram_host_pend.sv
module vram_host_pend
    import vram_arb_pkg::*;
(
    input  logic              clk2x,
    input  logic              rst_n,
    input  logic              slot,
    input  logic              req,
    input  logic              we,
    input  logic [BANK_W-1:0] bank,
    output logic              serve_vld,
    output logic              serve_we,
    output logic [BANK_W-1:0] serve_bank,
    output logic              ready
);

    host_pend_t pend_d, pend_q;
    logic       take;

    always_comb begin
        take       = req && !pend_q.vld;
        pend_d     = pend_q;
        serve_vld  = 1'b0;
        serve_we   = 1'b0;
        serve_bank = '0;
        if (slot) begin
            if (pend_q.vld) begin
                serve_vld  = 1'b1;
                serve_we   = pend_q.we;
                serve_bank = pend_q.bank;
            end else if (take) begin
                serve_vld  = 1'b1;
                serve_we   = we;
                serve_bank = bank;
            end
            pend_d.vld = 1'b0;
        end else if (take) begin
            pend_d.vld  = 1'b1;
            pend_d.we   = we;
            pend_d.bank = bank;
        end
    end

    always_ff @(posedge clk2x or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign ready = !pend_q.vld;

endmodule

// File: rtl/vram_bank_dec.sv
module vram_bank_dec #(
    parameter int NB = 3,
    parameter int BW = 2
) (
    input  logic          en,
    input  logic [BW-1:0] code,
    output logic [NB-1:0] hit
);

    // codes at or above NB select no bank
    for (genvar i = 0; i < NB; i++) begin : g_bank
        assign hit[i] = en && (code == BW'(i));
    end

endmodule

// File: rtl/vram_bus_arb.sv
module vram_bus_arb
    import vram_arb_pkg::*;
#(
    parameter int                NB       = NUM_BANKS,
    parameter int                BW       = BANK_W,
    parameter logic [AHI_W-1:0]  MAP_CODE = 2'b11
) (
    input  logic          clk2x,
    input  logic          rst_n,
    input  logic          gfx_ras,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [BW-1:0] cpu_bank,
    input  logic          gfx_draw_req,
    input  logic          gfx_we,
    input  logic [BW-1:0] gfx_bank,
    input  logic [AHI_W-1:0] gfx_addr_hi,
    output logic [NB-1:0] vde_n,
    output logic          gde_n,
    output logic          cde_n,
    output logic          rd_latch,
    output logic          dbd_we,
    output logic          cpu_ready
);

    logic          slot;
    logic          serve_vld, serve_we;
    logic [BW-1:0] serve_bank;
    logic [NB-1:0] cpu_hit, gfx_hit;
    logic          gfx_en, cpu_any, gfx_any, map_area;
    bus_ctl_t      ctl_d, ctl_q;

    vram_slot_gen u_slot (
        .clk2x      (clk2x),
        .rst_n      (rst_n),
        .row_strobe (gfx_ras),
        .slot       (slot)
    );

    vram_host_pend u_pend (
        .clk2x      (clk2x),
        .rst_n      (rst_n),
        .slot       (slot),
        .req        (cpu_req),
        .we         (cpu_we),
        .bank       (cpu_bank),
        .serve_vld  (serve_vld),
        .serve_we   (serve_we),
        .serve_bank (serve_bank),
        .ready      (cpu_ready)
    );

    vram_bank_dec #(.NB(NB), .BW(BW)) u_cpu_dec (
        .en   (serve_vld),
        .code (serve_bank),
        .hit  (cpu_hit)
    );

    assign gfx_en = gfx_draw_req && !slot;

    vram_bank_dec #(.NB(NB), .BW(BW)) u_gfx_dec (
        .en   (gfx_en),
        .code (gfx_bank),
        .hit  (gfx_hit)
    );

    always_comb begin
        cpu_any  = |cpu_hit;
        gfx_any  = |gfx_hit;
        map_area = (gfx_addr_hi == MAP_CODE);
        ctl_d    = BUS_IDLE;
        ctl_d.vde_n    = ~(cpu_hit | gfx_hit);
        ctl_d.cde_n    = !(cpu_any && serve_we);
        ctl_d.rd_latch = cpu_any && !serve_we;
        ctl_d.gde_n    = !(gfx_any && !map_area);
        ctl_d.dbd_we   = (cpu_any && serve_we) || (gfx_any && gfx_we);
    end

    always_ff @(posedge clk2x or negedge rst_n) begin
        if (!rst_n) ctl_q <= BUS_IDLE;
        else        ctl_q <= ctl_d;
    end

    assign vde_n    = ctl_q.vde_n;
    assign gde_n    = ctl_q.gde_n;
    assign cde_n    = ctl_q.cde_n;
    assign rd_latch = ctl_q.rd_latch;
    assign dbd_we   = ctl_q.dbd_we;

endmodule

// File: rtl/vram_bus_arb_chk.sv
module vram_bus_arb_chk #(
    parameter int NB = 3
) (
    input logic          clk2x,
    input logic          rst_n,
    input logic          slot,
    input logic [NB-1:0] vde_n,
    input logic          gde_n,
    input logic          cde_n,
    input logic          rd_latch,
    input logic          dbd_we,
    input logic          cpu_ready
);

    // R11
    bus_side_excl_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
        !(!gde_n && !cde_n));

    // R1
    host_in_slot_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
        (!cde_n || rd_latch) |-> $past(slot));

    // R2
    gfx_out_slot_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
        !gde_n |-> !$past(slot));

    // R8
    one_bank_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
        $onehot0(~vde_n));

    // R5
    host_write_dir_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
        !cde_n |-> (dbd_we && $countones(~vde_n) == 1));

    // R4
    host_read_dir_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
        rd_latch |-> (!dbd_we && cde_n && gde_n));

    // R9
    held_served_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
        (!cpu_ready && slot) |=> cpu_ready);

    // R10
    always @(posedge clk2x) begin
        if (!rst_n) begin
            reset_idle_chk: assert (&vde_n && gde_n && cde_n && !rd_latch && !dbd_we && cpu_ready);
        end
    end

endmodule

bind vram_bus_arb vram_bus_arb_chk #(.NB(NB)) u_chk (
    .clk2x     (clk2x),
    .rst_n     (rst_n),
    .slot      (slot),
    .vde_n     (vde_n),
    .gde_n     (gde_n),
    .cde_n     (cde_n),
    .rd_latch  (rd_latch),
    .dbd_we    (dbd_we),
    .cpu_ready (cpu_ready)
);

// File: tb/vram_bus_arb_tb.sv
module vram_bus_arb_tb;

    logic       clk2x = 1'b0;
    logic       rst_n = 1'b1;
    logic       gfx_ras = 1'b0;
    logic       cpu_req = 1'b0, cpu_we = 1'b0;
    logic [1:0] cpu_bank = 2'd0;
    logic       gfx_draw_req = 1'b0, gfx_we = 1'b0;
    logic [1:0] gfx_bank = 2'd0, gfx_addr_hi = 2'd0;
    logic [2:0] vde_n;
    logic       gde_n, cde_n, rd_latch, dbd_we, cpu_ready;

    int checks = 0;
    int errors = 0;

    always #2 clk2x = ~clk2x;

    vram_bus_arb u_dut (
        .clk2x(clk2x), .rst_n(rst_n), .gfx_ras(gfx_ras),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_bank(cpu_bank),
        .gfx_draw_req(gfx_draw_req), .gfx_we(gfx_we), .gfx_bank(gfx_bank),
        .gfx_addr_hi(gfx_addr_hi),
        .vde_n(vde_n), .gde_n(gde_n), .cde_n(cde_n), .rd_latch(rd_latch),
        .dbd_we(dbd_we), .cpu_ready(cpu_ready)
    );

    // stimulus {ras, creq, cwe, cbank, greq, gwe, gbank, gaddr}
    // expect   {vde_n, gde_n, cde_n, rd_latch, dbd_we, cpu_ready}
    localparam int NV = 13;
    localparam logic [18:0] VEC [NV] = '{
        19'b0_0_0_00_0_0_00_00_111_1_1_0_0_1, // R3 idle
        19'b1_1_0_01_0_0_00_00_101_1_1_1_0_1, // R4 host read bank 1
        19'b1_1_1_10_0_0_00_00_011_1_0_0_1_1, // R5 host write bank 2
        19'b1_1_1_00_0_0_00_00_110_1_0_0_1_1, // R5 host write bank 0
        19'b0_0_0_00_1_1_00_00_110_0_1_0_1_1, // R6 draw write bank 0
        19'b0_0_0_00_1_0_10_01_011_0_1_0_0_1, // R6 draw read bank 2
        19'b0_0_0_00_1_1_01_11_101_1_1_0_1_1, // R7 mapping region
        19'b1_0_0_00_1_1_00_00_111_1_1_0_0_1, // R1 draw in host slot ignored
        19'b1_1_1_11_0_0_00_00_111_1_1_0_0_1, // R8 host bank code 3
        19'b0_1_0_10_1_1_00_00_110_0_1_0_1_0, // R9 held, draw proceeds
        19'b0_0_0_00_0_0_00_00_111_1_1_0_0_0, // R9 still held
        19'b1_0_0_00_0_0_00_00_011_1_1_1_0_1, // R9 served in host slot
        19'b0_0_0_00_1_1_11_00_111_1_1_0_0_1  // R8 draw bank code 3
    };

    function automatic string tag_of(int i);
        case (i)
            0:       return "R3";
            1:       return "R4";
            2, 3:    return "R5";
            4, 5:    return "R6";
            6:       return "R7";
            7:       return "R1";
            8, 12:   return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(string req, logic [7:0] exp);
        logic [7:0] act;
        act = {vde_n, gde_n, cde_n, rd_latch, dbd_we, cpu_ready};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {vde_n,gde_n,cde_n,rd_latch,dbd_we,ready} actual %b expected %b",
                     req, act, exp);
        end
    endtask

    task automatic drive(logic [10:0] s);
        {gfx_ras, cpu_req, cpu_we, cpu_bank, gfx_draw_req, gfx_we, gfx_bank, gfx_addr_hi} = s;
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1 rst_n = 1'b0;
        #1 check("R10", 8'b111_1_1_0_0_1);
        @(posedge clk2x); @(posedge clk2x); #1;
        rst_n = 1'b1;

        // R12: each vector driven after an edge, result checked after the next edge
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][18:8]);
            @(posedge clk2x); #1;
            check(tag_of(i), VEC[i][7:0]);
        end
        drive('0);
        @(posedge clk2x); #1;
        check("R3", 8'b111_1_1_0_0_1);

        // R9: held request ignores a new request; the first one is served
        drive(11'b0_1_1_01_0_0_00_00);
        @(posedge clk2x); #1;
        check("R9", 8'b111_1_1_0_0_0);
        drive(11'b1_1_0_10_0_0_00_00);
        @(posedge clk2x); #1;
        check("R9", 8'b101_1_0_0_1_1);

        // R10: reset clears a held request and forces enables high at once
        drive(11'b0_1_0_00_0_0_00_00);
        @(posedge clk2x); #1;
        check("R9", 8'b111_1_1_0_0_0);
        drive(11'b1_0_0_00_0_0_00_00);
        #0.5 rst_n = 1'b0;
        #0.5 check("R10", 8'b111_1_1_0_0_1);
        @(posedge clk2x); #1;
        rst_n = 1'b1;
        @(posedge clk2x); #1;
        check("R10", 8'b111_1_1_0_0_1);

        // R10: asynchronous reset while a host write is on the bus
        drive(11'b1_1_1_00_0_0_00_00);
        @(posedge clk2x); #1;
        check("R5", 8'b110_1_0_0_1_1);
        rst_n = 1'b0;
        #1 check("R10", 8'b111_1_1_0_0_1);
        drive('0);
        @(posedge clk2x); #1;
        rst_n = 1'b1;

        // R2: slot level follows the strobe seen at the falling edge
        drive(11'b0_0_0_00_1_1_01_00);
        @(posedge clk2x); #1;
        check("R2", 8'b101_0_1_0_1_1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule